// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit up/down timer that produces symmetric (phase-correct) pulse-width modulation on two outputs. The count climbs from zero to a selected ceiling, turns round, falls back to zero and turns round again, so each period is twice the ceiling in enabled ticks. The ceiling comes from a 4-bit mode field: three fixed values, a capture/ceiling register, or the write buffer of compare channel A.

Each channel keeps a write buffer and an active compare value; the active value is refreshed from the buffer only on the tick at which the count turns round at the ceiling, so the waveform never glitches mid-period. Four sticky status flags report the floor, each channel's match and the capture-driven ceiling. The block has no data stream, so every pin is plain control or status: register writes are single-cycle strobes that are always accepted and there is no back-pressure.

Top module: `pcpwm_timer`

## Requirements
- R1: The ceiling follows `mode_sel`: 1 gives 0x00FF, 2 gives 0x01FF, 3 gives 0x03FF, 10 uses the capture register, 11 uses channel A's buffered compare value, any other code gives 0x00FF; a programmed ceiling below 3 is treated as 3.
- R2: With the ceiling at T, the state after n enabled ticks from reset is: count n counting up for 1 ≤ n mod 2T ≤ T, count 2T−(n mod 2T) counting down otherwise (count 0 down when n mod 2T = 0); each extreme is shown for one tick.
- R3: While `tick` is low, `count` and `dir_down` hold.
- R4: After reset `count` is 0, `dir_down` is 0, all flags are 0 and both channel states are low.
- R5: A compare write does not affect matching until the tick at which the count turns round at the ceiling.
- R6: Output mode 2 (non-inverted): a match on an up-counting tick drives the output low, a match on a down-counting tick drives it high.
- R7: Output mode 3 gives the complement of mode 2; modes 0 and 1 hold the output low.
- R8: In mode 2 a compare value of 0 keeps the output high for the whole period and a value at or above the ceiling keeps it low; otherwise the output is high exactly while (counting down and count < C) or (counting up and count ≤ C).
- R9: `flag_bottom` sets on the cycle after an enabled tick with count 0.
- R10: `flag_cmp_a`/`flag_cmp_b` set on the cycle after an enabled tick at which count equals that channel's active compare value.
- R11: `flag_top_cap` sets on the cycle after the turn-round tick at the ceiling when mode is 10; in mode 11 `flag_cmp_a` also sets on that tick.
- R12: Flags stay set until a one on `clr_flags` (bit 0 bottom, 1 compare A, 2 compare B, 3 capture); a set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one step per high cycle |
| wr_cmp_a | input | 1 | Write `wdata` to channel A buffer |
| wr_cmp_b | input | 1 | Write `wdata` to channel B buffer |
| wr_cap | input | 1 | Write `wdata` to capture/ceiling register |
| wr_mode | input | 1 | Load `mode_in` into the mode register |
| wdata | input | 16 | Write data |
| mode_in | input | 4 | Ceiling mode code |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| clr_flags | input | 4 | Write-one-to-clear flag strobes |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down |
| flag_bottom | output | 1 | Floor reached |
| flag_cmp_a | output | 1 | Channel A match |
| flag_cmp_b | output | 1 | Channel B match |
| flag_top_cap | output | 1 | Capture-defined ceiling reached |

## Verification
The main sweep runs capture-defined ceilings of 3, 4 and 5 against every compare value from 0 to one past the ceiling, with A non-inverted and B inverted, checking count, direction and both waveforms on every tick of the second period; this separates the ordinary duty cases from the two constant-level extremes and the inverted polarity. The fixed ceilings, the compare-A ceiling and an unlisted code are then run to their turn-round to tell the ceiling sources apart. Short directed runs isolate the enable hold, the buffered compare load, each flag's set cycle and the set-over-clear rule.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  localparam int CW = 16;
  localparam int MW = 4;

  localparam logic [MW-1:0] MODE_FIX8  = 4'd1;
  localparam logic [MW-1:0] MODE_FIX9  = 4'd2;
  localparam logic [MW-1:0] MODE_FIX10 = 4'd3;
  localparam logic [MW-1:0] MODE_CAP   = 4'd10;
  localparam logic [MW-1:0] MODE_CMPA  = 4'd11;

  localparam logic [1:0] OUT_NONINV = 2'd2;
  localparam logic [1:0] OUT_INV    = 2'd3;

  localparam logic [CW-1:0] MIN_CEIL = CW'(3);

  typedef struct packed {
    logic bottom;
    logic cmp_a;
    logic cmp_b;
    logic top_cap;
  } flag_ev_t;

  function automatic logic [CW-1:0] ceil_pick(input logic [MW-1:0] m,
                                              input logic [CW-1:0] cap,
                                              input logic [CW-1:0] cmpa);
    logic [CW-1:0] v;
    case (m)
      MODE_FIX9:  v = CW'(16'h01FF);
      MODE_FIX10: v = CW'(16'h03FF);
      MODE_CAP:   v = cap;
      MODE_CMPA:  v = cmpa;
      default:    v = CW'(16'h00FF);
    endcase
    if (v < MIN_CEIL) v = MIN_CEIL;
    return v;
  endfunction
endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] ceil_val,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         turn_top
);
  localparam logic [W-1:0] ONE = W'(1);

  assign turn_top = tick && !down && (cnt >= ceil_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (down) begin
        if (cnt == '0) begin
          down <= 1'b0;
          cnt  <= ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end else if (turn_top) begin
        down <= 1'b1;
        cnt  <= cnt - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [1:0]   out_mode,
  output logic [W-1:0] buf_val,
  output logic         match,
  output logic         pwm
);
  import pcpwm_pkg::*;

  logic [W-1:0] act_q;
  logic         lvl_q;

  assign match = tick && (cnt == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_val <= '0;
      act_q   <= '0;
      lvl_q   <= 1'b0;
    end else begin
      if (wr)    buf_val <= wdata;
      if (load)  act_q   <= buf_val;
      if (match) lvl_q   <= down;
    end
  end

  always_comb begin
    case (out_mode)
      OUT_NONINV: pwm = lvl_q;
      OUT_INV:    pwm = ~lvl_q;
      default:    pwm = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcpwm_flags.sv
module pcpwm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         q[i] <= 1'b0;
      else if (set_ev[i]) q[i] <= 1'b1;
      else if (clr[i])    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer #(
  parameter int W  = pcpwm_pkg::CW,
  parameter int NM = pcpwm_pkg::MW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_cmp_a,
  input  logic          wr_cmp_b,
  input  logic          wr_cap,
  input  logic          wr_mode,
  input  logic [W-1:0]  wdata,
  input  logic [NM-1:0] mode_in,
  input  logic [1:0]    out_mode_a,
  input  logic [1:0]    out_mode_b,
  input  logic [3:0]    clr_flags,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [W-1:0]  count,
  output logic          dir_down,
  output logic          flag_bottom,
  output logic          flag_cmp_a,
  output logic          flag_cmp_b,
  output logic          flag_top_cap
);
  import pcpwm_pkg::*;

  localparam int NCH = 2;

  logic [NM-1:0]  mode_q;
  logic [W-1:0]   cap_q;
  logic [W-1:0]   ceil_val;
  logic           turn_top;
  logic [NCH-1:0] ch_wr, ch_match, ch_pwm;
  logic [1:0]     ch_mode [NCH];
  logic [W-1:0]   ch_buf  [NCH];
  flag_ev_t       ev;
  logic [3:0]     fq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_in;
      if (wr_cap)  cap_q  <= wdata;
    end
  end

  assign ceil_val = ceil_pick(mode_q, cap_q, ch_buf[0]);

  pcpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ceil_val(ceil_val),
    .cnt(count), .down(dir_down), .turn_top(turn_top)
  );

  assign ch_wr      = {wr_cmp_b, wr_cmp_a};
  assign ch_mode[0] = out_mode_a;
  assign ch_mode[1] = out_mode_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pcpwm_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(turn_top),
      .wr(ch_wr[c]), .wdata(wdata), .cnt(count), .down(dir_down),
      .out_mode(ch_mode[c]), .buf_val(ch_buf[c]),
      .match(ch_match[c]), .pwm(ch_pwm[c])
    );
  end

  assign pwm_a = ch_pwm[0];
  assign pwm_b = ch_pwm[1];

  always_comb begin
    ev.bottom  = tick && (count == '0);
    ev.cmp_a   = ch_match[0] || (turn_top && mode_q == MODE_CMPA);
    ev.cmp_b   = ch_match[1];
    ev.top_cap = turn_top && (mode_q == MODE_CAP);
  end

  pcpwm_flags #(.N(4)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_ev({ev.top_cap, ev.cmp_b, ev.cmp_a, ev.bottom}),
    .clr(clr_flags), .q(fq)
  );

  assign flag_bottom  = fq[0];
  assign flag_cmp_a   = fq[1];
  assign flag_cmp_b   = fq[2];
  assign flag_top_cap = fq[3];
endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [1:0]   out_mode_a,
  input logic [3:0]   clr_flags,
  input logic         pwm_a,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         flag_bottom,
  input logic         flag_cmp_b
);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(count) && $stable(dir_down)));

  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == W'($past(count) + 1'b1)) || (count == W'($past(count) - 1'b1)));

  p_floor_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir_down && count == '0) |=> (!dir_down && count == W'(1)));

  p_floor_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0) |=> flag_bottom);

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cmp_b && !clr_flags[2]) |=> flag_cmp_b);

  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode_a == 2'd0 || out_mode_a == 2'd1) |-> !pwm_a);
endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .out_mode_a(out_mode_a),
  .clr_flags(clr_flags), .pwm_a(pwm_a), .count(count),
  .dir_down(dir_down), .flag_bottom(flag_bottom), .flag_cmp_b(flag_cmp_b)
);

// File: tb/pcpwm_timer_test.sv
module pcpwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, wr_cmp_a, wr_cmp_b, wr_cap, wr_mode;
  logic [15:0] wdata;
  logic [3:0]  mode_in, clr_flags;
  logic [1:0]  out_mode_a, out_mode_b;
  logic        pwm_a, pwm_b, dir_down;
  logic [15:0] count;
  logic        flag_bottom, flag_cmp_a, flag_cmp_b, flag_top_cap;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcpwm_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cmp_a(wr_cmp_a),
    .wr_cmp_b(wr_cmp_b), .wr_cap(wr_cap), .wr_mode(wr_mode),
    .wdata(wdata), .mode_in(mode_in), .out_mode_a(out_mode_a),
    .out_mode_b(out_mode_b), .clr_flags(clr_flags), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .count(count), .dir_down(dir_down),
    .flag_bottom(flag_bottom), .flag_cmp_a(flag_cmp_a),
    .flag_cmp_b(flag_cmp_b), .flag_top_cap(flag_top_cap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; wr_cmp_a = 0; wr_cmp_b = 0; wr_cap = 0; wr_mode = 0;
    wdata = '0; mode_in = '0; clr_flags = '0; out_mode_a = 2'd2; out_mode_b = 2'd3;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // kind: 0 compare A, 1 compare B, 2 capture, 3 mode
  task automatic wr(input int kind, input int val);
    wdata = 16'(val); mode_in = 4'(val);
    wr_cmp_a = (kind == 0); wr_cmp_b = (kind == 1);
    wr_cap = (kind == 2); wr_mode = (kind == 3);
    @(negedge clk);
    wr_cmp_a = 0; wr_cmp_b = 0; wr_cap = 0; wr_mode = 0;
  endtask

  function automatic int exp_cnt(input int n, input int t);
    int m = n % (2 * t);
    if (n == 0) return 0;
    if (m == 0) return 0;
    if (m <= t) return m;
    return 2 * t - m;
  endfunction

  function automatic bit exp_dn(input int n, input int t);
    int m = n % (2 * t);
    if (n == 0) return 0;
    return (m == 0) || (m > t);
  endfunction

  function automatic bit exp_hi(input int cnt, input bit dn, input int c, input int t);
    if (c == 0) return 1;
    if (c >= t) return 0;
    return dn ? (cnt < c) : (cnt <= c);
  endfunction

  // run a fixed or register ceiling to its turn-round, R1
  task automatic ceil_run(input int mode, input int t, input string tag);
    do_reset();
    if (mode == 11) wr(0, t);
    wr(3, mode);
    tick = 1;
    for (int n = 1; n <= 2 * t + 1; n++) begin
      @(negedge clk);
      if (n == t)     chk(count == 16'(t) && !dir_down, tag, int'(count), t);
      if (n == t + 1) chk(count == 16'(t - 1) && dir_down, tag, int'(count), t - 1);
      if (n == 2 * t) chk(count == 0 && dir_down, tag, int'(count), 0);
    end
    tick = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 reset state
    chk(count == 0 && !dir_down, "R4 count/dir", int'(count), 0);
    chk({flag_bottom, flag_cmp_a, flag_cmp_b, flag_top_cap} == 4'b0, "R4 flags",
        int'({flag_bottom, flag_cmp_a, flag_cmp_b, flag_top_cap}), 0);
    chk(!pwm_a && pwm_b, "R4 levels", int'({pwm_a, pwm_b}), 1);

    // R2 R6 R7 R8 sweep: capture ceilings, every compare value
    for (int t = 3; t <= 5; t++) begin
      for (int c = 0; c <= t + 1; c++) begin
        do_reset();
        wr(2, t); wr(3, 10); wr(0, c); wr(1, c);
        tick = 1;
        for (int n = 1; n <= 4 * t; n++) begin
          @(negedge clk);
          chk(int'(count) == exp_cnt(n, t) && dir_down == exp_dn(n, t),
              "R2 sequence", int'(count), exp_cnt(n, t));
          if (n > 2 * t) begin
            chk(pwm_a == exp_hi(exp_cnt(n, t), exp_dn(n, t), c, t),
                "R6 R8 non-inverted", int'(pwm_a), int'(exp_hi(exp_cnt(n, t), exp_dn(n, t), c, t)));
            chk(pwm_b == !exp_hi(exp_cnt(n, t), exp_dn(n, t), c, t),
                "R7 inverted", int'(pwm_b), int'(!exp_hi(exp_cnt(n, t), exp_dn(n, t), c, t)));
          end
        end
        tick = 0;
      end
    end

    // R7 disconnected output mode
    do_reset();
    out_mode_b = 2'd0;
    wr(2, 4); wr(3, 10); wr(1, 2);
    tick = 1;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      chk(!pwm_b, "R7 mode 0 low", int'(pwm_b), 0);
    end
    tick = 0;

    // R1 ceiling sources
    ceil_run(1, 255, "R1 mode 1");
    ceil_run(2, 511, "R1 mode 2");
    ceil_run(3, 1023, "R1 mode 3");
    ceil_run(11, 9, "R1 mode 11");
    ceil_run(5, 255, "R1 unlisted");
    ceil_run(10, 3, "R1 capture");

    // R3 hold with enable low
    do_reset();
    wr(2, 6); wr(3, 10);
    tick = 1;
    repeat (4) @(negedge clk);
    tick = 0;
    repeat (5) @(negedge clk);
    chk(count == 4 && !dir_down, "R3 hold", int'(count), 4);

    // R9 R12 floor flag, clear, set-wins
    do_reset();
    wr(2, 6); wr(3, 10);
    chk(!flag_bottom, "R9 before tick", int'(flag_bottom), 0);
    tick = 1; @(negedge clk); tick = 0;
    chk(flag_bottom, "R9 set", int'(flag_bottom), 1);
    repeat (2) @(negedge clk);
    chk(flag_bottom, "R12 sticky", int'(flag_bottom), 1);
    clr_flags = 4'b0001; @(negedge clk); clr_flags = 0;
    chk(!flag_bottom, "R12 clear", int'(flag_bottom), 0);
    do_reset();
    wr(2, 6); wr(3, 10);
    tick = 1; clr_flags = 4'b0001; @(negedge clk); tick = 0; clr_flags = 0;
    chk(flag_bottom, "R12 set wins", int'(flag_bottom), 1);

    // R5 buffered compare: ceiling 6, A = 2
    do_reset();
    wr(2, 6); wr(3, 10); wr(0, 2);
    tick = 1;
    @(negedge clk);                       // state 1
    clr_flags = 4'b0010;
    @(negedge clk); clr_flags = 0;        // state 2
    chk(!flag_cmp_a, "R12 clear A", int'(flag_cmp_a), 0);
    @(negedge clk);                       // state 3, tick at count 2 used old value 0
    chk(!flag_cmp_a, "R5 not yet loaded", int'(flag_cmp_a), 0);
    repeat (8) @(negedge clk);            // state 11, tick at count 2 going down
    chk(flag_cmp_a, "R5 loaded at top", int'(flag_cmp_a), 1);
    tick = 0;

    // R10 channel B match, ceiling 6, B = 3
    do_reset();
    wr(2, 6); wr(3, 10); wr(1, 3);
    tick = 1;
    repeat (7) @(negedge clk);            // state 7
    clr_flags = 4'b1111;
    @(negedge clk); clr_flags = 0;        // state 8
    chk(!flag_cmp_b, "R10 cleared", int'(flag_cmp_b), 0);
    @(negedge clk);                       // state 9
    chk(!flag_cmp_b, "R10 no match at 4", int'(flag_cmp_b), 0);
    @(negedge clk);                       // state 10
    chk(flag_cmp_b, "R10 match at 3", int'(flag_cmp_b), 1);
    tick = 0;

    // R11 capture ceiling flag, ceiling 4
    do_reset();
    wr(2, 4); wr(3, 10);
    tick = 1;
    repeat (4) @(negedge clk);
    chk(!flag_top_cap, "R11 before turn", int'(flag_top_cap), 0);
    @(negedge clk);
    chk(flag_top_cap, "R11 at turn", int'(flag_top_cap), 1);
    tick = 0;

    // R11 compare-A ceiling raises compare A flag at turn-round
    do_reset();
    wr(0, 5); wr(3, 11);
    tick = 1;
    @(negedge clk);
    clr_flags = 4'b0010; @(negedge clk); clr_flags = 0;
    repeat (3) @(negedge clk);            // state 5
    chk(!flag_cmp_a, "R11 A before turn", int'(flag_cmp_a), 0);
    @(negedge clk);                       // state 6
    chk(flag_cmp_a, "R11 A at turn", int'(flag_cmp_a), 1);
    tick = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule